// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit carries out the memory instruction class of a small 16-bit RISC core. When the core issues such an instruction, the unit adds a base register value and a second operand to form an address. The second operand is a register or a small signed constant, and one constant code takes a full 16-bit offset from the instruction's extension word. With pre-add the access uses the sum; with post-add it uses the untouched base. The unit runs one byte or word read or write over a simple request/wait memory bus. It can return the sum as a new base value, and it marks accesses to the top sixteenth of the 64 KB byte space as I/O.

The register file lives outside. The core presents the instruction together with the values of the base, second-source and transfer registers, and a flag telling whether register 0 holds zero, which the conditional-execute bit tests. The unit hands back one-cycle writeback pulses for the transfer register (load data) and for the base register (updated address). It also raises a fault pulse in place of a bus cycle when a word access would be misaligned.

Top module: `lsu_agu`

## Requirements
- R1: An `issue` pulse is acted on only when instruction bit 15 is 1 and the unit is idle. With bit 15 clear, no bus request, done pulse or writeback follows.
- R2: Instruction bit 12 selects the addressing order. When it is 1 (pre-add), `mem_addr` is base plus offset. When it is 0 (post-add), `mem_addr` is the unmodified base.
- R3: Bit 3 selects the offset source. When it is 0, the offset is `src_val`. When it is 1, bits 2..0 are a two's-complement constant (-3..+3), except that code 3'b100 takes the offset from `ext_word`.
- R4: When bit 13 is 1, `wb_base_en` pulses together with `done`, with `wb_base_idx` set to bits 6..4 and `wb_base_val` set to base plus offset. When bit 13 is 0, `wb_base_en` stays low.
- R5: A load (bit 14 = 0) pulses `wb_xfer_en` with `wb_xfer_idx` set to bits 10..8. A word load (bit 11 = 1) returns all of `mem_rdata`. A byte load returns the lane chosen by address bit 0 (0 = bits 7..0, 1 = bits 15..8), zero-extended.
- R6: A store (bit 14 = 1) drives `mem_we` = 1. A word store drives `mem_be` = 2'b11 and the whole transfer value. A byte store drives `mem_be` = 2'b01 for an even address and 2'b10 for an odd one, with the transfer register's low byte copied onto both data lanes.
- R7: `mem_io` is 1 exactly when the access address lies in 0xF000..0xFFFF.
- R8: A word access whose address has bit 0 set makes no bus request and no writeback. `align_fault` and `done` pulse one cycle after the issue edge.
- R9: While `mem_wait` is 1 during a request, the request and all of the bus outputs hold their values. The access completes on the first clock edge where `mem_wait` is 0.
- R10: When a load writes back and bits 10..8 equal bits 6..4, only the loaded data is written: `wb_xfer_en` pulses and `wb_base_en` stays low.
- R11: When bit 7 is 1 and `r0_zero` is 0, the instruction is skipped. `done` pulses one cycle after issue, with no bus request and no writeback.
- R12: `mem_req` rises one cycle after the issue edge. `done` and the writeback pulses appear for one cycle after the edge that completes the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Instruction presented this cycle |
| instr | input | 16 | Instruction word |
| ext_word | input | 16 | Extension word used by constant code 3'b100 |
| base_val | input | 16 | Value of the base register |
| src_val | input | 16 | Value of the second-source register |
| xfer_val | input | 16 | Value of the transfer register (store data) |
| r0_zero | input | 1 | Register 0 currently holds zero |
| mem_rdata | input | 16 | Memory read data |
| mem_wait | input | 1 | Memory stretches the current access |
| mem_req | output | 1 | Bus access in progress |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = word access, 0 = byte access |
| mem_be | output | 2 | Byte-lane enables |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_io | output | 1 | Address lies in I/O space |
| done | output | 1 | Instruction finished (one-cycle pulse) |
| align_fault | output | 1 | Misaligned word access rejected |
| wb_base_en | output | 1 | Base register write strobe |
| wb_base_idx | output | 3 | Base register index |
| wb_base_val | output | 16 | Updated address for the base register |
| wb_xfer_en | output | 1 | Transfer register write strobe |
| wb_xfer_idx | output | 3 | Transfer register index |
| wb_xfer_val | output | 16 | Load data for the transfer register |

## Verification
The bus request, address, lanes, I/O flag and write data all come from the issue edge through one register, so they are due one cycle after issue. A fault or a skip shows up in `done` at that same point. Load data and base writeback take one more edge beyond the last edge on which `mem_wait` is high. The bench drives every input on a falling edge and samples at the next falling edge after the edge concerned. While holding the wait for a chosen number of cycles, it compares the bus outputs on each of those cycles against the values captured first.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } lsu_state_e;

    typedef struct packed {
        logic       mem;
        logic       store;
        logic       wb;
        logic       pre;
        logic       word;
        logic [2:0] xfer;
        logic       cond;
        logic [2:0] base;
        logic       imm;
        logic [2:0] src;
    } lsu_op_t;

    function automatic lsu_op_t lsu_split(input logic [15:0] w);
        lsu_op_t o;
        o.mem   = w[15];
        o.store = w[14];
        o.wb    = w[13];
        o.pre   = w[12];
        o.word  = w[11];
        o.xfer  = w[10:8];
        o.cond  = w[7];
        o.base  = w[6:4];
        o.imm   = w[3];
        o.src   = w[2:0];
        return o;
    endfunction

endpackage

// File: rtl/lsu_addr.sv
module lsu_addr
    import lsu_pkg::*;
#(
    parameter int DW      = 16,
    parameter int IO_BITS = 4
) (
    input  lsu_op_t        op,
    input  logic [DW-1:0]  base_val,
    input  logic [DW-1:0]  src_val,
    input  logic [DW-1:0]  ext_word,
    output logic [DW-1:0]  sum,
    output logic [DW-1:0]  addr,
    output logic           is_io,
    output logic           misalign
);
    localparam logic [2:0] EXT_CODE = 3'b100;

    logic [DW-1:0] offset;

    always_comb begin
        if (!op.imm)
            offset = src_val;
        else if (op.src == EXT_CODE)
            offset = ext_word;
        else
            offset = {{(DW-3){op.src[2]}}, op.src};
        sum      = base_val + offset;
        addr     = op.pre ? sum : base_val;
        is_io    = &addr[DW-1 -: IO_BITS];
        misalign = op.word & addr[0];
    end

endmodule

// File: rtl/lsu_lanes.sv
module lsu_lanes #(
    parameter int DW = 16
) (
    input  logic                    word,
    input  logic [LW-1:0]           lane_idx,
    input  logic [DW-1:0]           xfer_val,
    input  logic [DW-1:0]           rdata,
    output logic [LANES-1:0]        be,
    output logic [DW-1:0]           wdata,
    output logic [DW-1:0]           ldata
);
    localparam int LANES = DW / 8;
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g]          = word | (lane_idx == LW'(g));
        assign wdata[g*8 +: 8] = word ? xfer_val[g*8 +: 8] : xfer_val[7:0];
    end

    always_comb begin
        if (word)
            ldata = rdata;
        else
            ldata = {{(DW-8){1'b0}}, rdata[lane_idx*8 +: 8]};
    end

endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
    import lsu_pkg::*;
#(
    parameter int DW      = 16,
    parameter int IO_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [15:0]   instr,
    input  logic [DW-1:0] ext_word,
    input  logic [DW-1:0] base_val,
    input  logic [DW-1:0] src_val,
    input  logic [DW-1:0] xfer_val,
    input  logic          r0_zero,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_wait,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_word,
    output logic [1:0]    mem_be,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_io,
    output logic          done,
    output logic          align_fault,
    output logic          wb_base_en,
    output logic [2:0]    wb_base_idx,
    output logic [DW-1:0] wb_base_val,
    output logic          wb_xfer_en,
    output logic [2:0]    wb_xfer_idx,
    output logic [DW-1:0] wb_xfer_val
);
    localparam int LANES = DW / 8;
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        lsu_state_e    state;
        logic [DW-1:0] addr;
        logic [DW-1:0] sum;
        logic          word;
        logic          we;
        logic          io;
        logic          wb;
        logic [2:0]    xfer_idx;
        logic [2:0]    base_idx;
        logic [DW-1:0] xfer_val;
        logic          done;
        logic          fault;
        logic          wbb_en;
        logic [DW-1:0] wbb_val;
        logic          wbx_en;
        logic [DW-1:0] wbx_val;
    } lsu_regs_t;

    lsu_regs_t state_d, state_q;

    lsu_op_t          op;
    logic [DW-1:0]    calc_sum, calc_addr;
    logic             calc_io, calc_misalign;
    logic [LANES-1:0] lane_be;
    logic [DW-1:0]    lane_wdata, lane_ldata;

    assign op = lsu_split(instr);

    lsu_addr #(.DW(DW), .IO_BITS(IO_BITS)) u_addr (
        .op       (op),
        .base_val (base_val),
        .src_val  (src_val),
        .ext_word (ext_word),
        .sum      (calc_sum),
        .addr     (calc_addr),
        .is_io    (calc_io),
        .misalign (calc_misalign)
    );

    lsu_lanes #(.DW(DW)) u_lanes (
        .word     (state_q.word),
        .lane_idx (state_q.addr[LW-1:0]),
        .xfer_val (state_q.xfer_val),
        .rdata    (mem_rdata),
        .be       (lane_be),
        .wdata    (lane_wdata),
        .ldata    (lane_ldata)
    );

    always_comb begin
        state_d        = state_q;
        state_d.done   = 1'b0;
        state_d.fault  = 1'b0;
        state_d.wbb_en = 1'b0;
        state_d.wbx_en = 1'b0;
        unique case (state_q.state)
            ST_IDLE: begin
                if (issue && op.mem) begin
                    if (op.cond && !r0_zero) begin
                        state_d.done = 1'b1;
                    end else if (calc_misalign) begin
                        state_d.done  = 1'b1;
                        state_d.fault = 1'b1;
                    end else begin
                        state_d.state    = ST_BUS;
                        state_d.addr     = calc_addr;
                        state_d.sum      = calc_sum;
                        state_d.word     = op.word;
                        state_d.we       = op.store;
                        state_d.io       = calc_io;
                        state_d.wb       = op.wb;
                        state_d.xfer_idx = op.xfer;
                        state_d.base_idx = op.base;
                        state_d.xfer_val = xfer_val;
                    end
                end
            end
            ST_BUS: begin
                if (!mem_wait) begin
                    state_d.state   = ST_IDLE;
                    state_d.done    = 1'b1;
                    state_d.wbx_en  = !state_q.we;
                    state_d.wbx_val = lane_ldata;
                    state_d.wbb_en  = state_q.wb &&
                        !(!state_q.we && (state_q.xfer_idx == state_q.base_idx));
                    state_d.wbb_val = state_q.sum;
                end
            end
            default: state_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mem_req     = (state_q.state == ST_BUS);
    assign mem_we      = mem_req & state_q.we;
    assign mem_word    = state_q.word;
    assign mem_be      = mem_req ? lane_be : 2'b00;
    assign mem_addr    = state_q.addr;
    assign mem_wdata   = lane_wdata;
    assign mem_io      = mem_req & state_q.io;
    assign done        = state_q.done;
    assign align_fault = state_q.fault;
    assign wb_base_en  = state_q.wbb_en;
    assign wb_base_idx = state_q.base_idx;
    assign wb_base_val = state_q.wbb_val;
    assign wb_xfer_en  = state_q.wbx_en;
    assign wb_xfer_idx = state_q.xfer_idx;
    assign wb_xfer_val = state_q.wbx_val;

endmodule

// File: rtl/lsu_agu_chk.sv
module lsu_agu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_wait,
    input logic        mem_we,
    input logic        mem_word,
    input logic [1:0]  mem_be,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic        done,
    input logic        align_fault,
    input logic        wb_base_en,
    input logic [2:0]  wb_base_idx,
    input logic        wb_xfer_en,
    input logic [2:0]  wb_xfer_idx
);

    a_r9_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_wait) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_be) && $stable(mem_wdata)));

    a_r12_done_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_wait) |=> (done && !mem_req));

    a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (done && !mem_req && !wb_base_en && !wb_xfer_en));

    a_r8_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_word) |-> !mem_addr[0]);

    a_r6_one_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_word) |-> ($countones(mem_be) == 1));

    a_r10_no_dual_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_base_en && wb_xfer_en) |-> (wb_base_idx != wb_xfer_idx));

    a_r4_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_base_en || wb_xfer_en) |-> done);

endmodule

bind lsu_agu lsu_agu_chk u_chk (.*);

// File: tb/lsu_agu_tb.sv
module lsu_agu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [15:0] instr = '0, ext_word = '0, base_val = '0, src_val = '0, xfer_val = '0;
    logic        r0_zero = 1'b1;
    logic [15:0] mem_rdata = '0;
    logic        mem_wait = 1'b0;
    logic        mem_req, mem_we, mem_word, mem_io, done, align_fault;
    logic [1:0]  mem_be;
    logic [15:0] mem_addr, mem_wdata, wb_base_val, wb_xfer_val;
    logic        wb_base_en, wb_xfer_en;
    logic [2:0]  wb_base_idx, wb_xfer_idx;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // captured observations of one operation
    logic        o_req, o_we, o_word, o_io, o_fault, o_held, o_done;
    logic        o_bb_en, o_bx_en;
    logic [1:0]  o_be;
    logic [2:0]  o_bb_idx, o_bx_idx;
    logic [15:0] o_addr, o_wdata, o_bb_val, o_bx_val;

    always #10 clk = ~clk;

    lsu_agu u_dut (.*);

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
            report();
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] ins, input logic [15:0] ext, input logic [15:0] base,
                          input logic [15:0] src, input logic [15:0] xfer, input logic r0z,
                          input logic [15:0] rdata, input int nwait);
        @(negedge clk);
        instr = ins; ext_word = ext; base_val = base; src_val = src; xfer_val = xfer;
        r0_zero = r0z; mem_rdata = rdata; mem_wait = (nwait > 0); issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        o_req = mem_req; o_addr = mem_addr; o_we = mem_we; o_word = mem_word; o_be = mem_be;
        o_wdata = mem_wdata; o_io = mem_io; o_fault = align_fault; o_held = 1'b1;
        if (mem_req) begin
            for (int i = 0; i < nwait; i++) begin
                @(negedge clk);
                if (!mem_req || mem_addr !== o_addr || mem_be !== o_be ||
                    mem_wdata !== o_wdata || done) o_held = 1'b0;
            end
            mem_wait = 1'b0;
            @(negedge clk);
        end
        o_done = done; o_bb_en = wb_base_en; o_bb_idx = wb_base_idx; o_bb_val = wb_base_val;
        o_bx_en = wb_xfer_en; o_bx_idx = wb_xfer_idx; o_bx_val = wb_xfer_val;
    endtask

    task automatic t_reset;
        chk("R12 reset mem_req", 16'(mem_req), 16'h0);
        chk("R12 reset done", 16'(done), 16'h0);
        chk("R4 reset wb_base_en", 16'(wb_base_en), 16'h0);
    endtask

    // word load, pre-add, register offset, writeback
    task automatic t_word_load_pre;
        run_op(16'hBA34, 16'h0, 16'h1000, 16'h0010, 16'h0, 1'b1, 16'hBEEF, 0);
        chk("R12 req after issue", 16'(o_req), 16'h1);
        chk("R2 pre-add address", o_addr, 16'h1010);
        chk("R3 register offset read", 16'(o_we), 16'h0);
        chk("R5 word load data", o_bx_val, 16'hBEEF);
        chk("R5 xfer idx", {o_bx_en, 12'h0, o_bx_idx}, 16'h8002);
        chk("R4 base value", o_bb_val, 16'h1010);
        chk("R4 base idx", {o_bb_en, 12'h0, o_bb_idx}, 16'h8003);
        chk("R12 done", 16'(o_done), 16'h1);
    endtask

    // byte load, post-add +1, odd address at the edge of I/O space, two wait cycles
    task automatic t_byte_load_post_wait;
        run_op(16'hA159, 16'h0, 16'hEFFF, 16'h0, 16'h0, 1'b1, 16'h5A7C, 2);
        chk("R2 post-add address", o_addr, 16'hEFFF);
        chk("R7 0xEFFF not io", 16'(o_io), 16'h0);
        chk("R9 held during wait", 16'(o_held), 16'h1);
        chk("R5 byte high lane zero-extended", o_bx_val, 16'h005A);
        chk("R3 constant +1 sum", o_bb_val, 16'hF000);
        chk("R9 completes after wait", 16'(o_done), 16'h1);
    endtask

    // byte store, pre-add -3, into I/O space, no writeback
    task automatic t_byte_store_io;
        run_op(16'hD41D, 16'h0, 16'hF013, 16'h0, 16'h00C3, 1'b1, 16'h0, 1);
        chk("R3 constant -3 address", o_addr, 16'hF010);
        chk("R7 io flag", 16'(o_io), 16'h1);
        chk("R6 write strobe", 16'(o_we), 16'h1);
        chk("R6 even byte lane", 16'(o_be), 16'h1);
        chk("R6 byte replicated", o_wdata, 16'hC3C3);
        chk("R4 no base writeback", 16'(o_bb_en), 16'h0);
        chk("R5 no xfer writeback on store", 16'(o_bx_en), 16'h0);
    endtask

    // word store, offset from extension word, writeback
    task automatic t_word_store_ext;
        run_op(16'hFE4C, 16'h0100, 16'h3000, 16'h0, 16'h1234, 1'b1, 16'h0, 0);
        chk("R3 extension offset", o_addr, 16'h3100);
        chk("R6 word lanes", 16'(o_be), 16'h3);
        chk("R6 word data", o_wdata, 16'h1234);
        chk("R7 low address not io", 16'(o_io), 16'h0);
        chk("R4 base gets sum", o_bb_val, 16'h3100);
        chk("R4 base strobe", 16'(o_bb_en), 16'h1);
    endtask

    task automatic t_misaligned;
        run_op(16'hB829, 16'h0, 16'h4000, 16'h0, 16'h0, 1'b1, 16'h0, 0);
        chk("R8 no request", 16'(o_req), 16'h0);
        chk("R8 fault pulse", 16'(o_fault), 16'h1);
        chk("R8 done pulse", 16'(o_done), 16'h1);
        chk("R8 no writeback", {15'h0, o_bb_en | o_bx_en}, 16'h0);
    endtask

    task automatic t_same_reg;
        run_op(16'hA91A, 16'h0, 16'h0500, 16'h0, 16'h0, 1'b1, 16'h7777, 0);
        chk("R2 post-add base", o_addr, 16'h0500);
        chk("R10 load wins", o_bx_val, 16'h7777);
        chk("R10 xfer strobe", 16'(o_bx_en), 16'h1);
        chk("R10 base suppressed", 16'(o_bb_en), 16'h0);
    endtask

    task automatic t_conditional;
        run_op(16'hBAB4, 16'h0, 16'h1000, 16'h0010, 16'h0, 1'b0, 16'h1111, 0);
        chk("R11 skipped no request", 16'(o_req), 16'h0);
        chk("R11 skipped done", 16'(o_done), 16'h1);
        chk("R11 skipped no writeback", {15'h0, o_bb_en | o_bx_en}, 16'h0);
        run_op(16'hBAB4, 16'h0, 16'h1000, 16'h0010, 16'h0, 1'b1, 16'h1111, 0);
        chk("R11 runs when r0 zero", o_addr, 16'h1010);
        chk("R11 runs load data", o_bx_val, 16'h1111);
    endtask

    task automatic t_not_memory;
        run_op(16'h3A34, 16'h0, 16'h1000, 16'h0010, 16'h0, 1'b1, 16'h0, 0);
        chk("R1 ignored no request", 16'(o_req), 16'h0);
        chk("R1 ignored no done", 16'(o_done), 16'h0);
        chk("R1 ignored no writeback", {15'h0, o_bb_en | o_bx_en}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_word_load_pre();
        t_byte_load_post_wait();
        t_byte_store_io();
        t_word_store_ext();
        t_misaligned();
        t_same_reg();
        t_conditional();
        t_not_memory();
        repeat (2) @(negedge clk);
        report();
    end

endmodule